// File: doc/BRIEF.md
# Dual-Scanline Display Fetch Controller

This block keeps two small line buffers (one for even display lines, one for odd display lines) topped up with pixel words from the frame buffer. A display timing generator drives it with three single-cycle trigger pulses, already in the logic clock domain. One pulse restarts the frame. The other two each ask for a refill of one of the two buffers. Only one trigger is active in any cycle.

Each buffer is a client of a shared memory-user bus, and a memory arbiter owns that bus. For every refill, the buffer raises its own request line and waits for the arbiter to assert that buffer's select line. While selected, the buffer presents a fetch descriptor in two fixed words at the top of its client address space: a read command with the line word count, and the current frame-buffer base address. It then accepts the line's data words into its storage.

Each buffer has its own line pointer. When a refill ends, that pointer steps forward by two line strides. The even buffer therefore covers lines 0, 2, 4, … and the odd buffer covers lines 1, 3, 5, …. A frame-start pulse rewinds both pointers.

Top module: `scanline_fetch_ctrl`

## Requirements
- R1: A fill pulse for one buffer (even = `fill_even_i`, odd = `fill_odd_i`) raises that buffer's request bit and busy bit at the next clock edge. The other buffer's bits do not change. Bit 0 of `mu_req_o` and `busy_o` is the even buffer and bit 1 is the odd buffer.
- R2: A buffer's request bit drops at the clock edge after its select bit is seen high. Its busy bit stays high until the edge after its select bit is seen low.
- R3: While a buffer is selected, a bus read (strobe high, write low) of client word 0xFFC returns a descriptor. Bits 31..24 hold the command code 0x00 (read), and bits 23..0 hold `LINE_WORDS`.
- R4: A bus read of client word 0xFFD returns the buffer's current base address. After reset or a frame-start pulse, the even base is `FB_BASE` and the odd base is `FB_BASE + LINE_STRIDE`.
- R5: When a refill completes (select falls), that buffer's base address increases by `2*LINE_STRIDE`. The other buffer's base does not change.
- R6: While a buffer is selected, a strobe with write high at a client word below `CACHE_DEPTH` stores `mu_wdata_i` at that index. A later read of the same index returns the stored word, and this holds across later refills until the word is overwritten.
- R7: A fill pulse for a buffer that is already busy is ignored. It does not queue a second request.
- R8: A buffer reacts to the bus only while its select bit is high and it has a pending or active refill. If no buffer is in that state, `mu_rdata_o` reads zero and writes change no stored word.
- R9: A client word that is neither below `CACHE_DEPTH` nor 0xFFC/0xFFD reads as zero, and writes to it are discarded.
- R10: After reset, both request bits and both busy bits are low and `mu_rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_i | input | 1 | Frame-start pulse; rewinds both line pointers |
| fill_even_i | input | 1 | Refill pulse for the even buffer |
| fill_odd_i | input | 1 | Refill pulse for the odd buffer |
| mu_req_o | output | 2 | Per-buffer request to the arbiter |
| mu_sel_i | input | 2 | Per-buffer select from the arbiter |
| mu_strobe_i | input | 1 | Bus access strobe |
| mu_write_i | input | 1 | High: client stores data; low: client drives data |
| mu_addr_i | input | 12 | Client word address |
| mu_wdata_i | input | 32 | Data from the arbiter |
| mu_rdata_o | output | 32 | Data to the arbiter (zero when no buffer responds) |
| busy_o | output | 2 | Per-buffer refill in progress |

## Verification
The embedded properties watch the request/select handshake on every cycle: a request clears once select is seen, busy only falls after select has dropped, and a busy buffer stays busy when it gets another pulse. They also check that each line pointer either rewinds or steps by exactly two strides, that a stored word reads back at its index, and that read data is never driven without an active selected buffer. Only the bench scenarios can show the values seen at the system level. These are the descriptor contents as the arbiter reads them, the sequence of base addresses over several alternating refills and a frame restart, the fact that a buffer's contents survive another buffer's refill and a stray select, and that a pulse to a busy buffer leaves no second request behind.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int CMD_W  = 8;
    localparam int CNT_W  = DATA_W - CMD_W;
    localparam int NCACHE = 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  count_t;

    // Handshake state of one buffer toward the arbiter
    typedef enum logic [1:0] {
        LS_IDLE  = 2'd0,
        LS_WAIT  = 2'd1,
        LS_SERVE = 2'd2
    } link_state_e;

    // Fetch command codes carried in the descriptor's top byte
    typedef enum logic [CMD_W-1:0] {
        CMD_READ  = 8'h00,
        CMD_WRITE = 8'h80
    } mem_cmd_e;

    // One bus beat as seen by every client
    typedef struct packed {
        logic  strobe;
        logic  write;
        addr_t addr;
        word_t data;
    } bus_beat_t;

    // Descriptor words sit at the top of the client address space
    localparam addr_t DESC_CMD_ADDR  = addr_t'((1 << ADDR_W) - 4);
    localparam addr_t DESC_BASE_ADDR = addr_t'((1 << ADDR_W) - 3);

    function automatic word_t make_cmd_word(mem_cmd_e cmd, count_t n);
        return {cmd, n};
    endfunction

endpackage

// File: rtl/dsf_link_fsm.sv
module dsf_link_fsm
    import dsf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic sel_i,
    output logic req_o,
    output logic busy_o,
    output logic active_o,
    output logic done_o
);

    link_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_IDLE:  if (trig_i) state_d = LS_WAIT;
            LS_WAIT:  if (sel_i)  state_d = LS_SERVE;
            LS_SERVE: if (!sel_i) state_d = LS_IDLE;
            default:              state_d = LS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= LS_IDLE;
        else     state_q <= state_d;
    end

    assign req_o    = (state_q == LS_WAIT);
    assign busy_o   = (state_q != LS_IDLE);
    assign active_o = sel_i && (state_q != LS_IDLE);
    assign done_o   = (state_q == LS_SERVE) && !sel_i;

    // R2
    req_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (req_o && sel_i) |=> !req_o);

    // R2
    busy_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> $past(!sel_i));

    // R7
    busy_retrigger_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && trig_i && sel_i) |=> (busy_o && !req_o));

    // R1
    trig_raises_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && trig_i) |=> (req_o && busy_o));

endmodule

// File: rtl/dsf_base_track.sv
module dsf_base_track
    import dsf_pkg::*;
#(
    parameter word_t BASE_INIT = 32'h0,
    parameter word_t STEP      = 32'h40
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  restart_i,
    input  logic  advance_i,
    output word_t base_o
);

    always_ff @(posedge clk) begin
        if (rst || restart_i) base_o <= BASE_INIT;
        else if (advance_i)   base_o <= base_o + STEP;
    end

    // R4
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (base_o == BASE_INIT));

    // R5
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        (advance_i && !restart_i) |=> (base_o == $past(base_o) + STEP));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!advance_i && !restart_i) |=> $stable(base_o));

endmodule

// File: rtl/dsf_line_store.sv
module dsf_line_store
    import dsf_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  word_t            wr_data_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output word_t            rd_data_o
);

    word_t mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    assign rd_data_o = mem_q[rd_idx_i];

    // R6
    store_readback_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en_i) && (rd_idx_i == $past(wr_idx_i)))
            |-> (rd_data_o == $past(wr_data_i)));

endmodule

// File: rtl/scanline_fetch_ctrl.sv
module scanline_fetch_ctrl
    import dsf_pkg::*;
#(
    parameter int    CACHE_DEPTH = 8,
    parameter int    LINE_WORDS  = 8,
    parameter word_t FB_BASE     = 32'h0010_0000,
    parameter word_t LINE_STRIDE = 32'h0000_0020
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        frame_start_i,
    input  logic        fill_even_i,
    input  logic        fill_odd_i,
    output logic [1:0]  mu_req_o,
    input  logic [1:0]  mu_sel_i,
    input  logic        mu_strobe_i,
    input  logic        mu_write_i,
    input  logic [11:0] mu_addr_i,
    input  logic [31:0] mu_wdata_i,
    output logic [31:0] mu_rdata_o,
    output logic [1:0]  busy_o
);

    localparam int    IDX_W      = $clog2(CACHE_DEPTH);
    localparam word_t PAIR_STEP  = word_t'(LINE_STRIDE * 2);
    localparam addr_t LINE_LIMIT = addr_t'(CACHE_DEPTH);
    localparam word_t DESC_WORD  = make_cmd_word(CMD_READ, count_t'(LINE_WORDS));

    bus_beat_t beat;
    assign beat = '{strobe: mu_strobe_i, write: mu_write_i,
                    addr: mu_addr_i, data: mu_wdata_i};

    logic in_line;
    logic [IDX_W-1:0] line_idx;
    assign in_line  = (beat.addr < LINE_LIMIT);
    assign line_idx = beat.addr[IDX_W-1:0];

    logic [NCACHE-1:0] trig_vec;
    logic [NCACHE-1:0] active_vec;
    logic [NCACHE-1:0] done_vec;
    word_t             resp_vec [NCACHE];

    assign trig_vec = {fill_odd_i, fill_even_i};

    for (genvar k = 0; k < NCACHE; k++) begin : g_buf
        word_t base_w;
        word_t line_w;
        word_t slot_w;
        logic  wr_en_w;

        dsf_link_fsm u_link (
            .clk      (clk),
            .rst      (rst),
            .trig_i   (trig_vec[k]),
            .sel_i    (mu_sel_i[k]),
            .req_o    (mu_req_o[k]),
            .busy_o   (busy_o[k]),
            .active_o (active_vec[k]),
            .done_o   (done_vec[k])
        );

        dsf_base_track #(
            .BASE_INIT (word_t'(FB_BASE + LINE_STRIDE * k)),
            .STEP      (PAIR_STEP)
        ) u_base (
            .clk       (clk),
            .rst       (rst),
            .restart_i (frame_start_i),
            .advance_i (done_vec[k]),
            .base_o    (base_w)
        );

        assign wr_en_w = active_vec[k] && beat.strobe && beat.write && in_line;

        dsf_line_store #(
            .DEPTH (CACHE_DEPTH)
        ) u_store (
            .clk       (clk),
            .rst       (rst),
            .wr_en_i   (wr_en_w),
            .wr_idx_i  (line_idx),
            .wr_data_i (beat.data),
            .rd_idx_i  (line_idx),
            .rd_data_o (line_w)
        );

        always_comb begin
            slot_w = '0;
            if (beat.addr == DESC_CMD_ADDR)       slot_w = DESC_WORD;
            else if (beat.addr == DESC_BASE_ADDR) slot_w = base_w;
            else if (in_line)                     slot_w = line_w;
        end

        assign resp_vec[k] = (active_vec[k] && beat.strobe && !beat.write)
                             ? slot_w : '0;
    end

    always_comb begin
        mu_rdata_o = '0;
        for (int k = 0; k < NCACHE; k++) mu_rdata_o = mu_rdata_o | resp_vec[k];
    end

    // R8
    rdata_source_chk: assert property (@(posedge clk) disable iff (rst)
        (mu_rdata_o != '0) |-> (|(mu_sel_i & busy_o)));

    // R1
    req_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
        |(mu_req_o & ~busy_o) == 1'b0);

endmodule

// File: tb/sim_scanline_fetch_ctrl.sv
module sim_scanline_fetch_ctrl;

    localparam int          CLK_PERIOD = 10;
    localparam int          WORDS      = 8;
    localparam logic [31:0] BASE0      = 32'h0010_0000;
    localparam logic [31:0] STRIDE     = 32'h0000_0020;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start_i = 1'b0;
    logic        fill_even_i = 1'b0;
    logic        fill_odd_i = 1'b0;
    logic [1:0]  mu_req_o;
    logic [1:0]  mu_sel_i = 2'b00;
    logic        mu_strobe_i = 1'b0;
    logic        mu_write_i = 1'b0;
    logic [11:0] mu_addr_i = '0;
    logic [31:0] mu_wdata_i = '0;
    logic [31:0] mu_rdata_o;
    logic [1:0]  busy_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    scanline_fetch_ctrl u0 (
        .clk(clk), .rst(rst), .frame_start_i(frame_start_i),
        .fill_even_i(fill_even_i), .fill_odd_i(fill_odd_i),
        .mu_req_o(mu_req_o), .mu_sel_i(mu_sel_i), .mu_strobe_i(mu_strobe_i),
        .mu_write_i(mu_write_i), .mu_addr_i(mu_addr_i), .mu_wdata_i(mu_wdata_i),
        .mu_rdata_o(mu_rdata_o), .busy_o(busy_o)
    );

    typedef struct {
        logic [31:0] val;
        string       tag;
    } item_t;

    item_t exp_q[$];
    item_t act_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pair observed bus reads with predicted values
    always @(negedge clk) begin
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            item_t e;
            item_t a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            check(a.val, e.val, e.tag);
        end
    end

    function automatic logic [31:0] pat(input logic [31:0] seed, input int i);
        return seed ^ (32'h0101_0101 * (i + 1)) ^ 32'(i << 20);
    endfunction

    task automatic pulse(input int which);
        @(negedge clk);
        frame_start_i = (which == 0);
        fill_even_i   = (which == 1);
        fill_odd_i    = (which == 2);
        @(negedge clk);
        frame_start_i = 1'b0;
        fill_even_i   = 1'b0;
        fill_odd_i    = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        item_t e;
        item_t o;
        @(negedge clk);
        mu_addr_i   = a;
        mu_write_i  = 1'b0;
        mu_strobe_i = 1'b1;
        e.val = exp;
        e.tag = tag;
        exp_q.push_back(e);
        #(CLK_PERIOD/4);
        o.val = mu_rdata_o;
        o.tag = tag;
        act_q.push_back(o);
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        mu_addr_i   = a;
        mu_wdata_i  = d;
        mu_write_i  = 1'b1;
        mu_strobe_i = 1'b1;
    endtask

    task automatic bus_idle();
        @(negedge clk);
        mu_strobe_i = 1'b0;
        mu_write_i  = 1'b0;
    endtask

    task automatic open_sel(input int k);
        @(negedge clk);
        mu_sel_i[k] = 1'b1;
        @(negedge clk);
        check({31'b0, mu_req_o[k]}, 32'd0, "R2 request cleared after select");
        check({31'b0, busy_o[k]},   32'd1, "R2 busy held while selected");
    endtask

    task automatic close_sel(input int k);
        @(negedge clk);
        mu_sel_i[k] = 1'b0;
        mu_strobe_i = 1'b0;
        mu_write_i  = 1'b0;
        @(negedge clk);
        check({31'b0, busy_o[k]}, 32'd0, "R2 busy released after select drop");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    localparam logic [31:0] SEED_A = 32'hA5A5_0000;
    localparam logic [31:0] SEED_B = 32'h5A5A_1111;
    localparam logic [31:0] SEED_C = 32'hC3C3_2222;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({30'b0, mu_req_o}, 32'd0, "R10 reset request");
        check({30'b0, busy_o},   32'd0, "R10 reset busy");
        check(mu_rdata_o,        32'd0, "R10 reset read data");

        pulse(0);
        pulse(1);
        check({30'b0, mu_req_o}, 32'd1, "R1 even request only");
        check({30'b0, busy_o},   32'd1, "R1 even busy only");

        // even refill, first line
        open_sel(0);
        bus_rd(12'hFFC, {8'h00, 24'(WORDS)}, "R3 descriptor command word");
        bus_rd(12'hFFD, BASE0, "R4 even base after frame start");
        for (int i = 0; i < WORDS; i++) bus_wr(12'(i), pat(SEED_A, i));
        bus_wr(12'h008, 32'hDEAD_BEEF);
        for (int i = 0; i < WORDS; i++) bus_rd(12'(i), pat(SEED_A, i), "R6 even readback");
        bus_rd(12'h008, 32'd0, "R9 word past depth");
        bus_rd(12'hFFE, 32'd0, "R9 unused descriptor word");
        close_sel(0);

        pulse(2);
        check({30'b0, mu_req_o}, 32'd2, "R1 odd request only");
        check({30'b0, busy_o},   32'd2, "R1 odd busy only");
        open_sel(1);
        bus_rd(12'hFFD, BASE0 + STRIDE, "R4 odd base after frame start");
        for (int i = 0; i < WORDS; i++) bus_wr(12'(i), pat(SEED_B, i));
        bus_rd(12'h005, pat(SEED_B, 5), "R6 odd readback");
        close_sel(1);

        // stray select on an idle buffer
        @(negedge clk);
        mu_sel_i[1] = 1'b1;
        bus_rd(12'hFFD, 32'd0, "R8 idle buffer stays silent");
        bus_wr(12'h000, 32'hFFFF_0000);
        bus_idle();
        mu_sel_i[1] = 1'b0;
        check({30'b0, mu_req_o}, 32'd0, "R8 stray select raises nothing");

        // even refill, second line, with a redundant pulse mid-service
        pulse(1);
        open_sel(0);
        bus_rd(12'hFFD, BASE0 + 2 * STRIDE, "R5 even base advanced");
        pulse(1);
        check({30'b0, mu_req_o}, 32'd0, "R7 pulse to busy buffer ignored");
        check({30'b0, busy_o},   32'd1, "R7 busy unchanged");
        for (int i = 0; i < WORDS; i++) bus_wr(12'(i), pat(SEED_C, i));
        close_sel(0);
        @(negedge clk);
        check({30'b0, mu_req_o}, 32'd0, "R7 no queued second request");

        pulse(2);
        open_sel(1);
        bus_rd(12'hFFD, BASE0 + 3 * STRIDE, "R5 odd base advanced");
        bus_rd(12'h000, pat(SEED_B, 0), "R8 odd word untouched by stray and even writes");
        bus_rd(12'h003, pat(SEED_B, 3), "R8 odd word untouched");
        close_sel(1);

        // new frame
        pulse(0);
        pulse(1);
        open_sel(0);
        bus_rd(12'hFFD, BASE0, "R4 even base rewound");
        bus_rd(12'h002, pat(SEED_C, 2), "R6 contents persist");
        close_sel(0);
        pulse(2);
        open_sel(1);
        bus_rd(12'hFFD, BASE0 + STRIDE, "R4 odd base rewound");
        close_sel(1);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule